// File: doc/BRIEF.md
# Bfloat16 Adder-Subtractor

This block adds or subtracts two 16-bit brain-float operands. Each word carries its sign in bit 15, a biased exponent (bias 127) in bits 14:7 and a 7-bit fraction in bits 6:0. A mode input requests subtraction. Subtraction inverts bit 15 of the second operand and then uses the same path as addition. In this text the second operand after that inversion is called the effective B.

The arithmetic is a single combinational path. It covers special-value screening, exponent alignment, magnitude add or subtract, and normalization. Its result is captured in an output register together with a valid flag. Rounding is not performed: bits shifted out are dropped. Some cases take fixed shortcuts:
- When the exponents differ by more than eight, the larger operand comes back unchanged.
- Exact cancellation gives positive zero.
- An exponent that would fall to zero or below during normalization gives positive zero instead of a denormal.

Top module: `bf16_addsub`

## Requirements
- R1: When operand A has an all-ones exponent and a nonzero fraction (NaN), the result is A bit for bit, whatever the effective B is.
- R2: When A is infinity (all-ones exponent, zero fraction), the result depends on the effective B:
  - B finite: the result is A.
  - B NaN: the result is the effective B.
  - B infinity with the same sign: the result is the effective B.
  - B infinity with the opposite sign: the result is the canonical NaN 0x7FC0.
- R3: When only the effective B has an all-ones exponent, the result is the effective B.
- R4: A zero operand (exponent 0 and fraction 0, either sign) passes the other operand through:
  - A zero: the result is the effective B.
  - Otherwise, B zero: the result is A.
- R5: With the mode bit at 1, the result equals the sum of A and B with bit 15 of B inverted.
- R6: For finite nonzero operands whose exponents differ by more than 8, the result is the operand with the larger exponent, unchanged (effective B when B is larger).
- R7: For operands of equal sign, the result is computed as follows:
  - The aligned significands (hidden bit 0x80 set when the exponent is nonzero) are added.
  - A carry into bit 8 shifts the sum right by one and raises the exponent by one.
  - The packed word is sign<<15 | exponent<<7 | sum[6:0].
- R8: An equal-sign sum whose exponent reaches 255 yields signed infinity (sign<<15 | 0x7F80). Two finite operands never produce a NaN.
- R9: For operands of opposite sign, the result is computed as follows:
  - The smaller aligned significand is subtracted from the larger.
  - The result takes the sign of the larger significand.
  - A zero difference yields 0x0000.
- R10: The difference is shifted left, with the exponent lowered one per step, until bit 7 is set. If the exponent would reach 0 or below, the result is 0x0000.
- R11: The smaller significand is shifted right by the exponent difference (up to 8) and the bits that drop out are discarded, with no rounding.
- R12: The output flags:
  - `out_valid` equals `in_valid` delayed by one clock.
  - `result` loads only in a cycle where `in_valid` is 1, and otherwise holds its value.
- R13: While `rst_n` is low, `out_valid` is 0 and `result` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| sub_mode | input | 1 | 1 = A minus B, 0 = A plus B |
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 16 | Registered sum or difference |

## Verification
The hardest branch to reach from the ports is the normalization flush. It needs a subtraction whose difference has several leading zeros while the larger exponent is already near the bottom of the range. The stimulus reaches it by subtracting a full-fraction word with exponent 1 from a word with exponent 2, which leaves a single low bit that would need seven left shifts. Exponent gaps of exactly 8 and exactly 9 are driven back to back, so that the alignment path (which shifts to zero) and the pass-through shortcut are told apart. Overflow to infinity is driven with the largest finite magnitudes of both signs.

// File: rtl/bf16_addsub_pkg.sv
package bf16_addsub_pkg;

  localparam int DEF_EXP_W = 8;
  localparam int DEF_MAN_W = 7;

  // Which source feeds the result register
  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_A    = 2'd1,
    PICK_B    = 2'd2,
    PICK_NAN  = 2'd3
  } pick_e;

endpackage

// File: rtl/bf16_special.sv
module bf16_special
  import bf16_addsub_pkg::*;
#(
  parameter int EXP_W = DEF_EXP_W,
  parameter int MAN_W = DEF_MAN_W,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a_word,
  input  logic [W-1:0] b_word,
  output pick_e        pick
);

  logic a_top, b_top, a_frac_nz, b_frac_nz, a_zero, b_zero;

  assign a_top     = &a_word[W-2:MAN_W];
  assign b_top     = &b_word[W-2:MAN_W];
  assign a_frac_nz = |a_word[MAN_W-1:0];
  assign b_frac_nz = |b_word[MAN_W-1:0];
  assign a_zero    = ~|a_word[W-2:0];
  assign b_zero    = ~|b_word[W-2:0];

  // Priority: A all-ones exponent, then B all-ones exponent, then zeros
  always_comb begin
    pick = PICK_NONE;
    if (a_top) begin
      if (a_frac_nz) begin
        pick = PICK_A;
      end else if (b_top) begin
        if (b_frac_nz || (a_word[W-1] == b_word[W-1])) pick = PICK_B;
        else                                           pick = PICK_NAN;
      end else begin
        pick = PICK_A;
      end
    end else if (b_top) begin
      pick = PICK_B;
    end else if (a_zero) begin
      pick = PICK_B;
    end else if (b_zero) begin
      pick = PICK_A;
    end
  end

endmodule

// File: rtl/bf16_align.sv
module bf16_align
  import bf16_addsub_pkg::*;
#(
  parameter int EXP_W  = DEF_EXP_W,
  parameter int MAN_W  = DEF_MAN_W,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1,
  localparam int DW    = EXP_W + 1
) (
  input  logic [W-1:0]     a_word,
  input  logic [W-1:0]     b_word,
  output logic [EXP_W-1:0] big_exp,
  output logic [SIG_W-1:0] sig_a,
  output logic [SIG_W-1:0] sig_b,
  output pick_e            gap_pick
);

  localparam logic [DW-1:0] GAP_MAX = DW'(SIG_W);

  logic [EXP_W-1:0] ea, eb;
  logic [SIG_W-1:0] ha, hb;
  logic [DW-1:0]    ab_gap, ba_gap;

  assign ea     = a_word[W-2:MAN_W];
  assign eb     = b_word[W-2:MAN_W];
  assign ha     = {|ea, a_word[MAN_W-1:0]};
  assign hb     = {|eb, b_word[MAN_W-1:0]};
  assign ab_gap = {1'b0, ea} - {1'b0, eb};
  assign ba_gap = {1'b0, eb} - {1'b0, ea};

  always_comb begin
    big_exp  = ea;
    sig_a    = ha;
    sig_b    = hb;
    gap_pick = PICK_NONE;
    if (ea > eb) begin
      if (ab_gap > GAP_MAX) gap_pick = PICK_A;
      sig_b = hb >> ab_gap;
    end else if (eb > ea) begin
      big_exp = eb;
      if (ba_gap > GAP_MAX) gap_pick = PICK_B;
      sig_a = ha >> ba_gap;
    end
  end

endmodule

// File: rtl/bf16_magnitude.sv
module bf16_magnitude
  import bf16_addsub_pkg::*;
#(
  parameter int EXP_W  = DEF_EXP_W,
  parameter int MAN_W  = DEF_MAN_W,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1,
  localparam int EW    = EXP_W + 2,
  localparam int LZ_W  = $clog2(SIG_W + 1)
) (
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic [EXP_W-1:0] big_exp,
  input  logic [SIG_W-1:0] sig_a,
  input  logic [SIG_W-1:0] sig_b,
  output logic [W-1:0]     mag_word
);

  localparam logic [EXP_W-1:0] EXP_ALL = '1;
  localparam logic signed [EW-1:0] EXP_LIM = $signed({2'b00, EXP_ALL});
  localparam logic signed [EW-1:0] ONE_S   = $signed(EW'(1));
  localparam logic signed [EW-1:0] ZERO_S  = $signed(EW'(0));

  logic [SIG_W:0]          sum;
  logic [SIG_W-1:0]        dif, nm;
  logic                    a_ge_b, sgn;
  logic [LZ_W-1:0]         lz;
  logic signed [EW-1:0]    exp_w, e;

  assign sum    = {1'b0, sig_a} + {1'b0, sig_b};
  assign a_ge_b = (sig_a >= sig_b);
  assign dif    = a_ge_b ? (sig_a - sig_b) : (sig_b - sig_a);
  assign exp_w  = $signed({2'b00, big_exp});

  // Leading-zero count of the difference; highest set bit wins
  always_comb begin
    lz = LZ_W'(SIG_W);
    for (int i = 0; i < SIG_W; i++) begin
      if (dif[i]) lz = LZ_W'(SIG_W - 1 - i);
    end
  end

  always_comb begin
    mag_word = '0;
    sgn      = sign_a;
    nm       = '0;
    e        = exp_w;
    if (sign_a == sign_b) begin
      nm = sum[SIG_W-1:0];
      if (sum[SIG_W]) begin
        nm = sum[SIG_W:1];
        e  = exp_w + ONE_S;
      end
      if (e >= EXP_LIM) mag_word = {sgn, EXP_ALL, {MAN_W{1'b0}}};
      else              mag_word = {sgn, e[EXP_W-1:0], nm[MAN_W-1:0]};
    end else begin
      sgn = a_ge_b ? sign_a : sign_b;
      e   = exp_w - $signed({{(EW-LZ_W){1'b0}}, lz});
      nm  = dif << lz;
      if (dif == '0)                       mag_word = '0;
      else if ((lz != '0) && (e <= ZERO_S)) mag_word = '0;
      else                                 mag_word = {sgn, e[EXP_W-1:0], nm[MAN_W-1:0]};
    end
  end

endmodule

// File: rtl/bf16_addsub.sv
module bf16_addsub
  import bf16_addsub_pkg::*;
#(
  parameter int EXP_W  = DEF_EXP_W,
  parameter int MAN_W  = DEF_MAN_W,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         sub_mode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  output logic [W-1:0] result
);

  localparam logic [W-1:0] NAN_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [W-1:0]     b_eff, mag_word, comb_word, res_d, res_q;
  logic [EXP_W-1:0] big_exp;
  logic [SIG_W-1:0] sig_a, sig_b;
  pick_e            spec_pick, gap_pick;
  logic             vld_d, vld_q;

  assign b_eff = {op_b[W-1] ^ sub_mode, op_b[W-2:0]};

  bf16_special #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_special (
    .a_word (op_a),
    .b_word (b_eff),
    .pick   (spec_pick)
  );

  bf16_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .a_word   (op_a),
    .b_word   (b_eff),
    .big_exp  (big_exp),
    .sig_a    (sig_a),
    .sig_b    (sig_b),
    .gap_pick (gap_pick)
  );

  bf16_magnitude #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_magnitude (
    .sign_a   (op_a[W-1]),
    .sign_b   (b_eff[W-1]),
    .big_exp  (big_exp),
    .sig_a    (sig_a),
    .sig_b    (sig_b),
    .mag_word (mag_word)
  );

  // Result select: special screen first, then gap shortcut, then arithmetic
  always_comb begin
    unique case (spec_pick)
      PICK_A:   comb_word = op_a;
      PICK_B:   comb_word = b_eff;
      PICK_NAN: comb_word = NAN_WORD;
      default: begin
        unique case (gap_pick)
          PICK_A:  comb_word = op_a;
          PICK_B:  comb_word = b_eff;
          default: comb_word = mag_word;
        endcase
      end
    endcase
  end

  // Next state with explicit load enable
  always_comb begin
    vld_d = in_valid;
    res_d = in_valid ? comb_word : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

endmodule

// File: rtl/bf16_addsub_chk.sv
module bf16_addsub_chk
  import bf16_addsub_pkg::*;
#(
  parameter int EXP_W = DEF_EXP_W,
  parameter int MAN_W = DEF_MAN_W,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         sub_mode,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         out_valid,
  input logic [W-1:0] result
);

  localparam logic [W-1:0] NAN_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [W-1:0] SIGN_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] b_eff;
  logic a_top, b_top, a_nan, a_inf, b_inf, a_zero, res_nan;

  assign b_eff   = op_b ^ (sub_mode ? SIGN_BIT : '0);
  assign a_top   = &op_a[W-2:MAN_W];
  assign b_top   = &b_eff[W-2:MAN_W];
  assign a_nan   = a_top & |op_a[MAN_W-1:0];
  assign a_inf   = a_top & ~|op_a[MAN_W-1:0];
  assign b_inf   = b_top & ~|b_eff[MAN_W-1:0];
  assign a_zero  = ~|op_a[W-2:0];
  assign res_nan = &result[W-2:MAN_W] & |result[MAN_W-1:0];

  a_r12_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r12_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  a_r1_nan_a: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_nan) |=> (result == $past(op_a)));

  a_r2_inf_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_inf && b_inf && (op_a[W-1] != b_eff[W-1])) |=> (result == NAN_WORD));

  a_r8_finite_no_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !a_top && !b_top) |=> !res_nan);

  a_r9_cancel_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !a_top && !a_zero && (op_a == (b_eff ^ SIGN_BIT))) |=> (result == '0));

endmodule

bind bf16_addsub bf16_addsub_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (.*);

// File: tb/bf16_addsub_tb.sv
`timescale 1ns/1ps
module bf16_addsub_tb;

  logic        clk, rst_n, in_valid, sub_mode;
  logic [15:0] op_a, op_b, result;
  logic        out_valid;
  int          total = 0;
  int          fails = 0;
  bit          done  = 0;

  bf16_addsub u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sub_mode  (sub_mode),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {req id, sub, a, b, expected}
  localparam int NV = 31;
  localparam logic [52:0] VEC [NV] = '{
    {4'd7,  1'b0, 16'h4080, 16'h4000, 16'h40C0},  // R7 plain add
    {4'd5,  1'b1, 16'h4080, 16'h4000, 16'h4000},  // R5 subtract
    {4'd7,  1'b0, 16'h4110, 16'h4040, 16'h4140},  // R7 aligned add
    {4'd10, 1'b1, 16'h4110, 16'h4040, 16'h40C0},  // R10 one-step normalize
    {4'd2,  1'b0, 16'h7F80, 16'h4000, 16'h7F80},  // R2 inf plus finite
    {4'd4,  1'b1, 16'h3F80, 16'h0000, 16'h3F80},  // R4 B zero
    {4'd1,  1'b0, 16'h7FC5, 16'hFF80, 16'h7FC5},  // R1 NaN in A
    {4'd2,  1'b0, 16'hFF80, 16'h7FC1, 16'h7FC1},  // R2 inf plus NaN
    {4'd2,  1'b0, 16'h7F80, 16'h7F80, 16'h7F80},  // R2 inf same sign
    {4'd2,  1'b1, 16'h7F80, 16'h7F80, 16'h7FC0},  // R2 inf minus inf
    {4'd2,  1'b0, 16'hFF80, 16'h7F80, 16'h7FC0},  // R2 opposite infs
    {4'd3,  1'b1, 16'h4000, 16'h7F80, 16'hFF80},  // R3 B inf, sign flipped
    {4'd3,  1'b0, 16'h3F80, 16'h7FC3, 16'h7FC3},  // R3 B NaN
    {4'd4,  1'b1, 16'h8000, 16'h4000, 16'hC000},  // R4 A zero
    {4'd4,  1'b0, 16'h4000, 16'h8000, 16'h4000},  // R4 B negative zero
    {4'd7,  1'b0, 16'h3F80, 16'h3F80, 16'h4000},  // R7 carry out
    {4'd11, 1'b0, 16'h3FFF, 16'h3FFF, 16'h407F},  // R11 carry drops a bit
    {4'd8,  1'b0, 16'h7F7F, 16'h7F7F, 16'h7F80},  // R8 overflow positive
    {4'd8,  1'b0, 16'hFF7F, 16'hFF7F, 16'hFF80},  // R8 overflow negative
    {4'd9,  1'b0, 16'h3F80, 16'hC000, 16'hBF80},  // R9 larger is B
    {4'd9,  1'b0, 16'h3F80, 16'hBFC0, 16'hBF00},  // R9 equal exponents
    {4'd9,  1'b1, 16'h3F80, 16'h3F80, 16'h0000},  // R9 self cancel
    {4'd9,  1'b0, 16'hBF80, 16'h3F80, 16'h0000},  // R9 cancel to +0
    {4'd10, 1'b1, 16'h0100, 16'h00FF, 16'h0000},  // R10 underflow flush
    {4'd10, 1'b1, 16'h4000, 16'h3FFF, 16'h3C80},  // R10 seven-step shift
    {4'd11, 1'b0, 16'h3F80, 16'h3C00, 16'h3F81},  // R11 gap 7
    {4'd11, 1'b0, 16'h3F80, 16'h3BC0, 16'h3F80},  // R11 gap 8 shifts to zero
    {4'd6,  1'b0, 16'h3F80, 16'h3B00, 16'h3F80},  // R6 gap 9, A larger
    {4'd6,  1'b1, 16'h3B00, 16'h3F80, 16'hBF80},  // R6 gap 9, B larger
    {4'd6,  1'b0, 16'hC000, 16'h3A00, 16'hC000},  // R6 gap 12
    {4'd5,  1'b1, 16'h4000, 16'hC000, 16'h4080}   // R5 minus negative
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    sub_mode = 1'b0;
    op_a     = '0;
    op_b     = '0;
    repeat (3) @(negedge clk);
    check("R13 reset valid", {15'd0, out_valid}, 16'h0000);
    check("R13 reset result", result, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      sub_mode = VEC[i][48];
      op_a     = VEC[i][47:32];
      op_b     = VEC[i][31:16];
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i][52:49], i), result, VEC[i][15:0]);
    end

    // R12: hold while in_valid is low, valid drops after one clock
    @(negedge clk);
    in_valid = 1'b0;
    op_a     = 16'h3F80;
    op_b     = 16'h3F80;
    sub_mode = 1'b0;
    @(negedge clk);
    check("R12 valid low", {15'd0, out_valid}, 16'h0000);
    check("R12 hold", result, 16'h4080);
    @(negedge clk);
    check("R12 hold second cycle", result, 16'h4080);

    // R12: one-clock latency
    in_valid = 1'b1;
    op_a     = 16'h4080;
    op_b     = 16'h4000;
    check("R12 valid before edge", {15'd0, out_valid}, 16'h0000);
    @(negedge clk);
    check("R12 valid after edge", {15'd0, out_valid}, 16'h0001);
    check("R12 result after edge", result, 16'h40C0);
    in_valid = 1'b0;

    // R13: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    check("R13 async valid", {15'd0, out_valid}, 16'h0000);
    check("R13 async result", result, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule